// File: doc/BRIEF.md
# Palette Colour Loader with Phased Channel Writes

This block holds a 256-entry colour lookup table with 8-bit red, green and blue channels. Software fills it over a 32-bit write bus through a 16-byte register window. The window holds an entry-select register and a single colour register. A two-bit phase counter steers each write to the colour register to red, then green, then blue. Only the most significant byte of each bus word carries data.

A scanout engine reads the table through its own read port, separate from the bus. It presents an entry number and receives the packed colour one clock later. Bus reads of the window always return zero and change no state. After blue has been written the selected entry stays the same, so three further colour writes rewrite that same entry.

Top module: `palette_dac_wport`

## Requirements
- R1: The register number is bus address bits [3:2]. Address bits [1:0] are ignored. Register 0 is the entry select and register 1 is the colour data.
- R2: A write to register 0 loads the selected entry from write-data bits [31:24] and returns the phase counter to red (phase 0).
- R3: A register 1 write in phase 0 stores bits [31:24] into the red channel of the selected entry and moves to phase 1. At most one channel is written per bus write.
- R4: A register 1 write in phase 1 stores bits [31:24] into green and moves to phase 2.
- R5: A register 1 write in phase 2 stores bits [31:24] into blue and returns to phase 0. The selected entry does not change, so the next colour write lands in red of the same entry.
- R6: Writes to registers 2 and 3 change no table entry, no phase and no selected entry.
- R7: Bus read data is always zero. A bus read does not disturb the phase or the selected entry.
- R8: After reset, entry 255 reads 0xFFFFFF and every other entry reads 0x000000. The selected entry and the phase are both 0.
- R9: Write-data bits [23:0] never reach the table.
- R10: The scanout port returns {red[23:16], green[15:8], blue[7:0]} of the requested entry on the clock after the request. A colour write is visible to any request presented after the write's clock edge.
- R11: Loading the entry select in the middle of a red-green-blue sequence abandons that sequence. The next colour write goes to red of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe (no side effect) |
| bus_addr | input | 4 | Byte address within the register window |
| bus_wdata | input | 32 | Bus write data; only [31:24] is used |
| bus_rdata | output | 32 | Bus read data, always zero |
| scan_idx | input | 8 | Scanout entry request |
| scan_rgb | output | 24 | Packed colour of the entry requested the previous cycle |

## Verification
The bench loads the entry select in the middle of a sequence. A design that kept its phase would put the next byte into green or blue instead of red. Writes to registers 2 and 3 are placed between colour writes. A decoder that folded them onto the colour register would advance the phase, and later bytes would land in the wrong channel. Addresses with nonzero low bits and bus words with busy low bytes expose decoding from the wrong bits. Reads after a mid-run reset confirm that the white entry 255 and the black entries come back, and that the phase restarts at red.

// File: rtl/palwr_pkg.sv
package palwr_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GRN   = 2'd1,
    PH_BLU   = 2'd2,
    PH_SPARE = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    RG_SELECT = 2'd0,
    RG_COLOUR = 2'd1,
    RG_RSV2   = 2'd2,
    RG_RSV3   = 2'd3
  } regsel_e;

  localparam int NUM_CHAN = 3;

  // register number from a byte address inside the window
  function automatic regsel_e reg_of(input logic [3:0] addr);
    return regsel_e'(addr[3:2]);
  endfunction

  // phase progression; any unused code folds back to red
  function automatic phase_e next_phase(input phase_e ph);
    case (ph)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  // channel number targeted by a colour write in a given phase
  // 0 = red, 1 = green, 2 = blue (unused code acts as blue)
  function automatic int unsigned chan_of(input phase_e ph);
    case (ph)
      PH_RED:  return 0;
      PH_GRN:  return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/palwr_decode.sv
module palwr_decode #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CH_W   = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_load,
  output logic              col_write,
  output logic [CH_W-1:0]   wbyte
);
  import palwr_pkg::*;

  localparam int LOW_W = DATA_W - CH_W;

  regsel_e rsel;
  logic [LOW_W-1:0] unused_low;

  always_comb begin
    rsel      = reg_of(addr[3:0]);
    sel_load  = wr_en && (rsel == RG_SELECT);
    col_write = wr_en && (rsel == RG_COLOUR);
  end

  assign wbyte      = wdata[DATA_W-1 -: CH_W];
  assign unused_low = wdata[LOW_W-1:0];

  generate
    if (ADDR_W > 4) begin : g_wide_addr
      logic [ADDR_W-5:0] unused_hi;
      assign unused_hi = addr[ADDR_W-1:4];
    end
  endgenerate

endmodule

// File: rtl/palwr_sequencer.sv
module palwr_sequencer #(
  parameter int IDX_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sel_load,
  input  logic                            col_write,
  input  logic [7:0]                      new_sel,
  output logic [IDX_W-1:0]                cur_index,
  output palwr_pkg::phase_e               cur_phase,
  output logic [palwr_pkg::NUM_CHAN-1:0]  chan_we
);
  import palwr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_index <= '0;
      cur_phase <= PH_RED;
    end else if (sel_load) begin
      cur_index <= IDX_W'(new_sel);
      cur_phase <= PH_RED;
    end else if (col_write) begin
      cur_phase <= next_phase(cur_phase);
    end
  end

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_we
      assign chan_we[c] = col_write && (chan_of(cur_phase) == c);
    end
  endgenerate

endmodule

// File: rtl/palwr_store.sv
module palwr_store #(
  parameter int ENTRIES = 256,
  parameter int CH_W    = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RGB_W  = CH_W * palwr_pkg::NUM_CHAN
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [palwr_pkg::NUM_CHAN-1:0] chan_we,
  input  logic [IDX_W-1:0]               wr_index,
  input  logic [CH_W-1:0]                wbyte,
  input  logic [IDX_W-1:0]               rd_index,
  output logic [RGB_W-1:0]               rd_rgb
);
  import palwr_pkg::*;

  // reset colour: the last entry is full white, the rest black
  function automatic logic [CH_W-1:0] boot_val(input int unsigned e);
    return (e == ENTRIES - 1) ? {CH_W{1'b1}} : '0;
  endfunction

  logic [CH_W-1:0] chan_rd [NUM_CHAN];

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic [CH_W-1:0] mem [ENTRIES];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int e = 0; e < ENTRIES; e++) mem[e] <= boot_val(e);
        end else if (chan_we[c]) begin
          mem[wr_index] <= wbyte;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) chan_rd[c] <= '0;
        else        chan_rd[c] <= mem[rd_index];
      end

      // channel 0 (red) occupies the top byte
      assign rd_rgb[RGB_W-1-c*CH_W -: CH_W] = chan_rd[c];
    end
  endgenerate

endmodule

// File: rtl/palette_dac_wport.sv
module palette_dac_wport #(
  parameter int ENTRIES = 256,
  parameter int CH_W    = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RGB_W  = CH_W * palwr_pkg::NUM_CHAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  scan_idx,
  output logic [RGB_W-1:0]  scan_rgb
);
  import palwr_pkg::*;

  logic                sel_load;
  logic                col_write;
  logic [CH_W-1:0]     wbyte;
  logic [IDX_W-1:0]    cur_index;
  phase_e              cur_phase;
  logic [NUM_CHAN-1:0] chan_we;
  logic                unused_rd;
  logic [7:0]          sel_byte;

  assign unused_rd = bus_rd_en;
  assign bus_rdata = '0;

  palwr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)
  ) u_decode (
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .sel_load (sel_load),
    .col_write(col_write),
    .wbyte    (wbyte)
  );

  assign sel_byte = 8'(wbyte);

  palwr_sequencer #(
    .IDX_W(IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_load (sel_load),
    .col_write(col_write),
    .new_sel  (sel_byte),
    .cur_index(cur_index),
    .cur_phase(cur_phase),
    .chan_we  (chan_we)
  );

  palwr_store #(
    .ENTRIES(ENTRIES), .CH_W(CH_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_we (chan_we),
    .wr_index(cur_index),
    .wbyte   (wbyte),
    .rd_index(scan_idx),
    .rd_rgb  (scan_rgb)
  );

endmodule

// File: rtl/palette_dac_wport_chk.sv
module palette_dac_wport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [7:0]  cur_index,
  input logic [1:0]  cur_phase,
  input logic [2:0]  chan_we
);

  logic is_sel, is_col, is_rsv;
  assign is_sel = bus_wr_en && (bus_addr[3:2] == 2'd0);
  assign is_col = bus_wr_en && (bus_addr[3:2] == 2'd1);
  assign is_rsv = bus_wr_en && bus_addr[3];

  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_sel |=> (cur_index == $past(bus_wdata[31:24])) && (cur_phase == 2'd0));

  p_red_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && cur_phase == 2'd0) |-> chan_we == 3'b001 ##1 cur_phase == 2'd1);

  p_one_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_we));

  p_grn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && cur_phase == 2'd1) |-> chan_we == 3'b010 ##1 cur_phase == 2'd2);

  p_blu_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && cur_phase == 2'd2) |=> (cur_phase == 2'd0) && $stable(cur_index));

  p_rsv_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_rsv |-> (chan_we == 3'b000) ##1 ($stable(cur_phase) && $stable(cur_index)));

  p_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !bus_wr_en) |=> $stable(cur_phase) && $stable(cur_index));

  p_phase_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_phase != 2'd3);

endmodule

bind palette_dac_wport palette_dac_wport_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en),
  .bus_addr (bus_addr[3:0]),
  .bus_wdata(bus_wdata),
  .cur_index(8'(cur_index)),
  .cur_phase(cur_phase),
  .chan_we  (chan_we)
);

// File: tb/palette_dac_wport_bench.sv
module palette_dac_wport_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  scan_idx = '0;
  logic [23:0] scan_rgb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  palette_dac_wport u_palette_dac_wport (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scan_idx(scan_idx), .scan_rgb(scan_rgb)
  );

  // bench model of the table, built from the requirements
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_sel;
  int         m_ph;

  task automatic model_reset();
    for (int e = 0; e < 256; e++) begin
      m_r[e] = (e == 255) ? 8'hFF : 8'h00;
      m_g[e] = m_r[e];
      m_b[e] = m_r[e];
    end
    m_sel = 0;
    m_ph  = 0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    logic [7:0] top;
    top = d[31:24];
    if (a[3:2] == 2'd0) begin
      m_sel = top;
      m_ph  = 0;
    end else if (a[3:2] == 2'd1) begin
      if (m_ph == 0)      begin m_r[m_sel] = top; m_ph = 1; end
      else if (m_ph == 1) begin m_g[m_sel] = top; m_ph = 2; end
      else                begin m_b[m_sel] = top; m_ph = 0; end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
    model_write(a, d);
  endtask

  task automatic scan_check(input string req, input logic [7:0] e);
    @(negedge clk);
    scan_idx = e;
    @(negedge clk);
    check(req, {8'h00, scan_rgb}, {8'h00, m_r[e], m_g[e], m_b[e]});
  endtask

  // {addr, wdata, entry to inspect}
  localparam logic [43:0] VEC [17] = '{
    {4'h0, 32'h05_DEAD00, 8'h05},  // R2 select entry 5
    {4'h4, 32'h11_ABCDEF, 8'h05},  // R3 R9 red, busy low bytes
    {4'h4, 32'h22_FFFFFF, 8'h05},  // R4 green
    {4'h4, 32'h33_000001, 8'h05},  // R5 blue
    {4'h4, 32'h44_123456, 8'h05},  // R5 back to red, same entry
    {4'h8, 32'h99_999999, 8'h05},  // R6 register 2 ignored
    {4'hC, 32'h77_777777, 8'h05},  // R6 register 3 ignored
    {4'h4, 32'h55_000000, 8'h05},  // R6 phase kept: green
    {4'h0, 32'hFF_000000, 8'hFF},  // R11 reselect mid sequence
    {4'h4, 32'h01_000000, 8'hFF},  // R11 lands in red of 255
    {4'h1, 32'h80_000000, 8'h80},  // R1 low address bits ignored
    {4'h6, 32'h12_000000, 8'h80},  // R1 red
    {4'h7, 32'h34_000000, 8'h80},  // R1 green
    {4'h5, 32'h56_000000, 8'h80},  // R1 blue
    {4'hD, 32'hEE_000000, 8'h80},  // R6 ignored
    {4'h0, 32'h00_FFFFFF, 8'h00},  // R2 select entry 0
    {4'h4, 32'hA5_5A5A5A, 8'h00}   // R10 write visible next read
  };

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset contents
    scan_check("R8", 8'd0);
    scan_check("R8", 8'd1);
    scan_check("R8", 8'd128);
    scan_check("R8", 8'd254);
    scan_check("R8", 8'd255);

    for (int i = 0; i < 17; i++) begin
      bus_write(VEC[i][43:40], VEC[i][39:8]);
      scan_check("R10 vector", VEC[i][7:0]);
    end

    // R7 reads return zero and leave the phase alone
    bus_write(4'h0, 32'h40_000000);
    bus_write(4'h4, 32'h61_000000);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = 4'h4;
    @(negedge clk);
    check("R7", bus_rdata, 32'h0);
    bus_addr = 4'h0;
    @(negedge clk);
    check("R7", bus_rdata, 32'h0);
    bus_rd_en = 1'b0;
    bus_write(4'h4, 32'h62_000000);   // must still be green
    scan_check("R7", 8'h40);

    // R8 reset in mid sequence restores contents and phase
    bus_write(4'h4, 32'h63_000000);
    bus_write(4'h4, 32'h64_000000);   // red again, phase now 1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    scan_check("R8", 8'h05);
    scan_check("R8", 8'hFF);
    scan_check("R8", 8'h40);
    bus_write(4'h4, 32'hC3_000000);   // red of entry 0
    scan_check("R8", 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule